// File: doc/BRIEF.md
# Hardware Cursor Overlay Engine

This block draws a 32x32 hardware cursor over a streaming 16-bit display pixel path in 1-5-5-5 format. Host software sets it up through a small indexed byte register file and one 32-bit position register. The byte registers hold the cursor image base address, the enable bit and the doubling bit. Writes to the two address registers are guarded by an unlock key. The image lives in external memory, and the block reads it through a valid/ready read port that returns data after a fixed latency.

Before each display line, the video timing pulses `line_start` with the number of the upcoming line. If that line crosses the cursor, the block fetches the matching cursor row (32 words) into a line buffer. During the line, each incoming pixel is compared with the cursor's horizontal span. A pixel inside the span is either replaced by or XORed with the buffered cursor word. A pixel outside the span passes through unchanged. Position, base, enable, doubling and suppress settings are taken into the working copy on `frame_start` only.

Top module: `cursor_overlay`

## Requirements
- R1: After reset every indexed register reads 0, the position register reads 0, the extended registers are locked, `pix_out_valid` is 0 and `mem_req_valid` is 0.
- R2: A position write keeps X from bits [11:0] and Y from bits [27:16]. A read returns Y in [27:16] and X in [11:0], with all other bits 0.
- R3: Writing key 0x57 to index 0x1F unlocks the extended registers, and any other value written there locks them. While locked, writes to index 0x30 and 0x31 are ignored and reads of them return 0. Index 0x1F reads back 1 when unlocked. Index 0x0A is always writable and readable.
- R4: The image base is the byte address {idx30[6:0], idx31[7:3], 11'b0}. Cursor row r, column c is read from base + r*64 + c*2. A request that is not accepted holds its address until `mem_req_ready` is high.
- R5: On `line_start`, when the line crosses the cursor, exactly 32 requests are issued for the cursor row (line_y − cursor_y). Responses fill columns 0..31 in the order they arrive.
- R6: A cursor word with bit 15 = 1 replaces bits [14:0] of the display pixel. A word with bit 15 = 0 XORs its bits [14:0] into the display pixel. Bit 15 of the display pixel always passes through.
- R7: A pixel outside the cursor's span passes through unchanged. So does every pixel when enable (idx31 bit 0) is 0 or when suppress (idx0A bit 5) is 1.
- R8: No cursor pixel is drawn when cursor X ≥ `active_w` or cursor Y ≥ `active_h`.
- R9: With doubling (idx31 bit 1) set, each cursor pixel covers 2x2 display pixels (64x64 on screen). Row and column are the halved offsets.
- R10: `pix_out`, `pix_out_valid`, `pix_out_hs` and `pix_out_vs` follow their inputs after exactly one clock.
- R11: Register changes reach the drawing path only on `frame_start`. A `line_start` in the same cycle as `frame_start` already uses the new settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_wr | input | 1 | Indexed register write strobe |
| idx_addr | input | 8 | Register index for write and read |
| idx_wdata | input | 8 | Indexed write data |
| idx_rdata | output | 8 | Indexed read data for `idx_addr` |
| pos_wr | input | 1 | Position register write strobe |
| pos_wdata | input | 32 | Position write data |
| pos_rdata | output | 32 | Position read data |
| active_w | input | 12 | Active display width |
| active_h | input | 12 | Active display height |
| frame_start | input | 1 | Frame start pulse, loads the working settings |
| line_start | input | 1 | Pulse in blanking before a line, starts the fetch |
| line_y | input | 12 | Number of the upcoming or current line |
| pix_in_valid | input | 1 | Input pixel valid |
| pix_in | input | 16 | Input display pixel, 1-5-5-5 |
| pix_in_hs | input | 1 | Input horizontal sync |
| pix_in_vs | input | 1 | Input vertical sync |
| beam_x | input | 12 | Horizontal position of the input pixel |
| pix_out_valid | output | 1 | Output pixel valid |
| pix_out | output | 16 | Composited pixel |
| pix_out_hs | output | 1 | Delayed horizontal sync |
| pix_out_vs | output | 1 | Delayed vertical sync |
| mem_req_valid | output | 1 | Cursor read request valid |
| mem_req_ready | input | 1 | Cursor read request accepted |
| mem_req_addr | output | 23 | Cursor read byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 16 | Read data word |

## Verification
The loading of new settings at frame start and the start of a row fetch can fall in the same cycle. In that case the fetch must use the settings being loaded, not the old ones. The bench first moves the cursor without a frame pulse and confirms that the old position is still drawn. It then pulses `frame_start` and `line_start` together on a line that only the new position crosses. The composited pixels are compared against a model that uses only the new position and base.

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
  parameter int CW = 12,
  parameter int PW = 16,
  parameter int CSZ = 32,
  parameter logic [7:0] IDX_CSTART = 8'h0A,
  parameter logic [7:0] IDX_BASE_HI = 8'h30,
  parameter logic [7:0] IDX_BASE_LO = 8'h31,
  parameter logic [7:0] IDX_UNLOCK = 8'h1F,
  parameter logic [7:0] UNLOCK_KEY = 8'h57
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_wr,
  input  logic [7:0]    idx_addr,
  input  logic [7:0]    idx_wdata,
  output logic [7:0]    idx_rdata,
  input  logic          pos_wr,
  input  logic [31:0]   pos_wdata,
  output logic [31:0]   pos_rdata,
  input  logic [CW-1:0] active_w,
  input  logic [CW-1:0] active_h,
  input  logic          frame_start,
  input  logic          line_start,
  input  logic [CW-1:0] line_y,
  input  logic          pix_in_valid,
  input  logic [PW-1:0] pix_in,
  input  logic          pix_in_hs,
  input  logic          pix_in_vs,
  input  logic [CW-1:0] beam_x,
  output logic          pix_out_valid,
  output logic [PW-1:0] pix_out,
  output logic          pix_out_hs,
  output logic          pix_out_vs,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [22:0]   mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [PW-1:0] mem_rsp_data
);
  localparam int AW = 23;
  localparam int CB = $clog2(CSZ);
  localparam int DW = CW + 1;

  logic [7:0] r_cstart, r_hi, r_lo;
  logic unlocked;
  logic [CW-1:0] pos_x, pos_y;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_cstart <= '0; r_hi <= '0; r_lo <= '0; unlocked <= 1'b0;
    end else if (idx_wr) begin
      case (idx_addr)
        IDX_UNLOCK:  unlocked <= (idx_wdata == UNLOCK_KEY);
        IDX_CSTART:  r_cstart <= idx_wdata;
        IDX_BASE_HI: if (unlocked) r_hi <= idx_wdata;
        IDX_BASE_LO: if (unlocked) r_lo <= idx_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (idx_addr)
      IDX_UNLOCK:  idx_rdata = {7'b0, unlocked};
      IDX_CSTART:  idx_rdata = r_cstart;
      IDX_BASE_HI: idx_rdata = unlocked ? r_hi : 8'h00;
      IDX_BASE_LO: idx_rdata = unlocked ? r_lo : 8'h00;
      default:     idx_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_x <= '0; pos_y <= '0;
    end else if (pos_wr) begin
      pos_x <= pos_wdata[CW-1:0];
      pos_y <= pos_wdata[16+CW-1:16];
    end
  end

  assign pos_rdata = (32'(pos_y) << 16) | 32'(pos_x);
  logic unused_pos;
  assign unused_pos = ^{pos_wdata[31:16+CW], pos_wdata[15:CW]};

  // working copy, loaded at frame start
  logic [CW-1:0] lv_x, lv_y;
  logic [AW-1:0] lv_base;
  logic lv_en, lv_dbl, lv_off;
  logic [AW-1:0] sh_base;
  assign sh_base = {r_hi[6:0], r_lo[7:3], 11'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lv_x <= '0; lv_y <= '0; lv_base <= '0;
      lv_en <= 1'b0; lv_dbl <= 1'b0; lv_off <= 1'b0;
    end else if (frame_start) begin
      lv_x <= pos_x; lv_y <= pos_y; lv_base <= sh_base;
      lv_en <= r_lo[0]; lv_dbl <= r_lo[1]; lv_off <= r_cstart[5];
    end
  end

  logic [CW-1:0] ef_x, ef_y;
  logic [AW-1:0] ef_base;
  logic ef_en, ef_dbl, ef_off;
  assign ef_x    = frame_start ? pos_x : lv_x;
  assign ef_y    = frame_start ? pos_y : lv_y;
  assign ef_base = frame_start ? sh_base : lv_base;
  assign ef_en   = frame_start ? r_lo[0] : lv_en;
  assign ef_dbl  = frame_start ? r_lo[1] : lv_dbl;
  assign ef_off  = frame_start ? r_cstart[5] : lv_off;

  logic [DW-1:0] ef_span, dy;
  logic v_hit, shown;
  logic [CB-1:0] row;
  logic [AW-1:0] row_base;
  assign ef_span  = ef_dbl ? DW'(2*CSZ) : DW'(CSZ);
  assign dy       = {1'b0, line_y} - {1'b0, ef_y};
  assign v_hit    = (line_y >= ef_y) && (dy < ef_span);
  assign shown    = ef_en && !ef_off && (ef_x < active_w) && (ef_y < active_h);
  assign row      = ef_dbl ? dy[CB:1] : dy[CB-1:0];
  assign row_base = ef_base + (AW'(row) << (CB + 1));

  // row fetch
  logic fetching, line_hit;
  logic [CB:0] req_cnt;
  logic [CB-1:0] rsp_cnt;
  logic [AW-1:0] line_base;
  logic [PW-1:0] lbuf [CSZ];

  assign mem_req_valid = fetching && !req_cnt[CB];
  assign mem_req_addr  = line_base + (AW'(req_cnt[CB-1:0]) << 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetching <= 1'b0; line_hit <= 1'b0; req_cnt <= '0; rsp_cnt <= '0; line_base <= '0;
    end else if (line_start) begin
      fetching  <= v_hit && shown;
      line_hit  <= v_hit && shown;
      req_cnt   <= '0;
      rsp_cnt   <= '0;
      line_base <= row_base;
    end else if (fetching) begin
      if (mem_req_valid && mem_req_ready) req_cnt <= req_cnt + 1'b1;
      if (mem_rsp_valid) begin
        rsp_cnt <= rsp_cnt + 1'b1;
        if (rsp_cnt == CB'(CSZ - 1)) fetching <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fetching && mem_rsp_valid && !line_start) lbuf[rsp_cnt] <= mem_rsp_data;
  end

  // compositing
  logic [DW-1:0] lv_span, dx;
  logic h_hit;
  logic [CB-1:0] col;
  logic [PW-1:0] cur, mixed;
  assign lv_span = lv_dbl ? DW'(2*CSZ) : DW'(CSZ);
  assign dx      = {1'b0, beam_x} - {1'b0, lv_x};
  assign h_hit   = line_hit && (beam_x >= lv_x) && (dx < lv_span);
  assign col     = lv_dbl ? dx[CB:1] : dx[CB-1:0];
  assign cur     = lbuf[col];
  assign mixed   = cur[PW-1] ? {pix_in[PW-1], cur[PW-2:0]} : (pix_in ^ {1'b0, cur[PW-2:0]});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_out_valid <= 1'b0; pix_out <= '0; pix_out_hs <= 1'b0; pix_out_vs <= 1'b0;
    end else begin
      pix_out_valid <= pix_in_valid;
      pix_out_hs    <= pix_in_hs;
      pix_out_vs    <= pix_in_vs;
      pix_out       <= h_hit ? mixed : pix_in;
    end
  end

  p_lat_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pix_in_valid |=> pix_out_valid);
  p_lat_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_in_valid |=> !pix_out_valid);
  p_lock_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr && !unlocked && idx_addr == IDX_BASE_HI) |=> $stable(r_hi));
  p_lock_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr && !unlocked && idx_addr == IDX_BASE_LO) |=> $stable(r_lo));
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready && !line_start) |=> (mem_req_valid && $stable(mem_req_addr)));
  p_frame_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(lv_x) && $stable(lv_y) && $stable(lv_base)));
  p_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_in_valid && !line_hit) |=> (pix_out == $past(pix_in)));
  p_req_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fetching |-> (req_cnt <= (CB+1)'(CSZ)));
endmodule

// File: tb/cursor_overlay_bench.sv
`timescale 1ns/1ps
module cursor_overlay_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic idx_wr = 0, pos_wr = 0, frame_start = 0, line_start = 0;
  logic [7:0] idx_addr = 0, idx_wdata = 0, idx_rdata;
  logic [31:0] pos_wdata = 0, pos_rdata;
  logic [11:0] active_w = 12'd640, active_h = 12'd480, line_y = 0, beam_x = 0;
  logic pix_in_valid = 0, pix_in_hs = 0, pix_in_vs = 0;
  logic [15:0] pix_in = 0, pix_out;
  logic pix_out_valid, pix_out_hs, pix_out_vs;
  logic mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [22:0] mem_req_addr;
  logic [15:0] mem_rsp_data;

  cursor_overlay u_cursor_overlay (.*);

  int total = 0, bad = 0;
  logic stall = 0;
  logic tick = 0;

  function automatic logic [15:0] img(input logic [22:0] a);
    return {a[1] ^ a[6], a[15:1] ^ {8'h00, a[22:16]}};
  endfunction

  logic p0v = 0, p1v = 0;
  logic [22:0] p0a = 0, p1a = 0;
  always @(posedge clk) begin
    tick <= ~tick;
    p0v <= mem_req_valid && mem_req_ready; p0a <= mem_req_addr;
    p1v <= p0v; p1a <= p0a;
  end
  assign mem_req_ready = !stall || tick;
  assign mem_rsp_valid = p1v;
  assign mem_rsp_data  = img(p1a);

  // bench copy of programmed and working settings
  int p_x = 0, p_y = 0, m_x = 0, m_y = 0;
  logic [7:0] p_hi = 0, p_lo = 0, p_cs = 0, m_hi = 0, m_lo = 0, m_cs = 0;
  logic p_unl = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_idx(input logic [7:0] a, input logic [7:0] d);
    idx_wr = 1; idx_addr = a; idx_wdata = d;
    @(negedge clk); idx_wr = 0;
    if (a == 8'h1F) p_unl = (d == 8'h57);
    else if (a == 8'h0A) p_cs = d;
    else if (a == 8'h30 && p_unl) p_hi = d;
    else if (a == 8'h31 && p_unl) p_lo = d;
  endtask

  task automatic rd_idx(input string req, input logic [7:0] a, input logic [7:0] e);
    idx_addr = a; #1; chk(req, 32'(idx_rdata), 32'(e));
  endtask

  task automatic wr_pos(input logic [31:0] d);
    pos_wr = 1; pos_wdata = d; @(negedge clk); pos_wr = 0;
    p_x = int'(d[11:0]); p_y = int'(d[27:16]);
  endtask

  task automatic take_frame();
    m_x = p_x; m_y = p_y; m_hi = p_hi; m_lo = p_lo; m_cs = p_cs;
  endtask

  task automatic pulse(input logic fs, input logic ls, input int y);
    frame_start = fs; line_start = ls; line_y = 12'(y);
    @(negedge clk); frame_start = 0; line_start = 0;
    if (fs) take_frame();
    repeat (stall ? 90 : 45) @(negedge clk);
  endtask

  function automatic logic [15:0] expect_pix(input int bx, input int by, input logic [15:0] pin);
    int span, dxv, dyv, r, c;
    logic [22:0] base;
    logic [15:0] w;
    if (!(m_lo[0] && !m_cs[5] && m_x < int'(active_w) && m_y < int'(active_h))) return pin;
    span = m_lo[1] ? 64 : 32;
    dxv = bx - m_x; dyv = by - m_y;
    if (dxv < 0 || dyv < 0 || dxv >= span || dyv >= span) return pin;
    r = m_lo[1] ? dyv / 2 : dyv;
    c = m_lo[1] ? dxv / 2 : dxv;
    base = {m_hi[6:0], m_lo[7:3], 11'b0};
    w = img(base + 23'(r * 64 + c * 2));
    return w[15] ? {pin[15], w[14:0]} : (pin ^ {1'b0, w[14:0]});
  endfunction

  task automatic stream(input string req, input int y, input int x0, input int n);
    for (int i = 0; i < n; i++) begin
      logic [15:0] pv;
      pv = 16'((x0 + i) * 7 + y * 13) ^ 16'hA5C3;
      pix_in_valid = 1; beam_x = 12'(x0 + i); pix_in = pv;
      pix_in_hs = i[0]; pix_in_vs = i[1];
      @(negedge clk);
      chk(req, {12'h0, pix_out_valid, pix_out_hs, pix_out_vs, 1'b0, pix_out},
               {12'h0, 1'b1, i[0], i[1], 1'b0, expect_pix(x0 + i, y, pv)});
    end
    pix_in_valid = 0; pix_in_hs = 0; pix_in_vs = 0;
    @(negedge clk);
    chk({req, " R10 valid drop"}, 32'(pix_out_valid), 32'd0);
  endtask

  task automatic t_reset();
    rd_idx("R1 idx0A", 8'h0A, 8'h00);
    rd_idx("R1 lock", 8'h1F, 8'h00);
    chk("R1 pos", pos_rdata, 32'h0);
    chk("R1 out valid", 32'(pix_out_valid), 32'h0);
    chk("R1 req", 32'(mem_req_valid), 32'h0);
  endtask

  task automatic t_pos();
    wr_pos(32'hFFFF_FFFF);
    chk("R2 trunc", pos_rdata, 32'h0FFF_0FFF);
    wr_pos(32'h0123_0456);
    chk("R2 fields", pos_rdata, 32'h0123_0456);
  endtask

  task automatic t_lock();
    wr_idx(8'h30, 8'h55);
    wr_idx(8'h1F, 8'h57);
    rd_idx("R3 locked write dropped", 8'h30, 8'h00);
    rd_idx("R3 unlocked flag", 8'h1F, 8'h01);
    wr_idx(8'h30, 8'h12);
    wr_idx(8'h31, 8'hA9);
    rd_idx("R3 hi", 8'h30, 8'h12);
    rd_idx("R3 lo", 8'h31, 8'hA9);
    wr_idx(8'h1F, 8'h00);
    rd_idx("R3 locked read", 8'h30, 8'h00);
    wr_idx(8'h30, 8'h7F);
    wr_idx(8'h0A, 8'h03);
    rd_idx("R3 idx0A open", 8'h0A, 8'h03);
    wr_idx(8'h1F, 8'h57);
    rd_idx("R3 kept", 8'h30, 8'h12);
    wr_idx(8'h0A, 8'h00);
  endtask

  task automatic t_draw();
    wr_pos({4'h0, 12'd50, 4'h0, 12'd100});
    pulse(1, 0, 0);
    pulse(0, 1, 49); stream("R7 above", 49, 96, 8);
    pulse(0, 1, 50); stream("R4 R5 R6 row0", 50, 96, 40);
    pulse(0, 1, 81); stream("R6 row31", 81, 96, 40);
    pulse(0, 1, 82); stream("R7 below", 82, 120, 8);
  endtask

  task automatic t_stall();
    stall = 1;
    pulse(0, 1, 60); stream("R4 backpressure", 60, 98, 36);
    stall = 0;
  endtask

  task automatic t_double();
    wr_idx(8'h31, 8'hAB);
    pulse(1, 0, 0);
    pulse(0, 1, 50 + 1);  stream("R9 row0 twice", 51, 96, 72);
    pulse(0, 1, 50 + 63); stream("R9 last", 113, 96, 72);
    pulse(0, 1, 50 + 64); stream("R9 past", 114, 140, 8);
    wr_idx(8'h31, 8'hA9);
  endtask

  task automatic t_disable();
    wr_idx(8'h0A, 8'h20);
    pulse(1, 0, 0);
    pulse(0, 1, 60); stream("R7 suppress", 60, 100, 8);
    wr_idx(8'h0A, 8'h00);
    wr_idx(8'h31, 8'hA8);
    pulse(1, 0, 0);
    pulse(0, 1, 60); stream("R7 enable off", 60, 100, 8);
    wr_idx(8'h31, 8'hA9);
  endtask

  task automatic t_offscreen();
    wr_pos({4'h0, 12'd10, 4'h0, 12'd640});
    pulse(1, 0, 0);
    pulse(0, 1, 12); stream("R8 x off", 12, 636, 10);
    wr_pos({4'h0, 12'd479, 4'h0, 12'd639});
    pulse(1, 0, 0);
    pulse(0, 1, 479); stream("R8 edge drawn", 479, 636, 8);
  endtask

  task automatic t_shadow();
    wr_pos({4'h0, 12'd200, 4'h0, 12'd300});
    wr_idx(8'h30, 8'h05);
    pulse(0, 1, 479); stream("R11 old kept", 479, 636, 6);
    pulse(1, 1, 205); stream("R11 same cycle", 205, 296, 40);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_pos();
    t_lock();
    t_draw();
    t_stall();
    t_double();
    t_disable();
    t_offscreen();
    t_shadow();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule